// File: doc/BRIEF.md
# DTMF Command Latch and Controller

This block is the control front end of a dual-tone dialler driven by a microprocessor. A processor places a 4-bit binary key code on a data bus and raises a tone-enable strobe. The block synchronises that strobe and detects its low-to-high edge. At that edge it captures the code and turns it into two divide ratios, one for the low-group tone channel and one for the high-group tone channel. It enables those channels and releases a mute flag for a speech network. When the strobe falls, both channels stop and mute is asserted again. At every other time the data bus is ignored, so the processor may use it for other work.

A test mode makes only one tone. When the active-low single-tone input is low at capture, only one channel runs, and the group select input picks which one. The oscillator, the tone synthesis, the analog summing and the output driver lie outside this block.

Top module: `dtmf_cmd_ctrl`

## Requirements
- R1: After reset, `mute` is 1, `lowRun` and `highRun` are 0, and both ratio outputs are 0.
- R2: A low-to-high change of `toneEnAsync` captures `keyCode`. The outputs change on the (SYNC_STAGES+1)-th rising clock edge after the change, and not before.
- R3: `keyCode` has no effect while the tone is held on or while the block is idle. The ratio outputs keep their values until the next capture.
- R4: The low-group ratio index gives 0→184 (697 Hz), 1→166 (770 Hz), 2→150 (852 Hz) and 3→136 (941 Hz). The high-group index gives 0→106 (1209 Hz), 1→96 (1336 Hz), 2→86 (1477 Hz) and 3→78 (1633 Hz). For codes 1 to 9 (binary 0001 to 1001), code n gives low index (n-1)/3 and high index (n-1) mod 3.
- R5: Code 10 (1010) gives low index 3 with high index 1. Code 11 (1011) gives low index 3 with high index 0. Code 12 (1100) gives low index 3 with high index 2.
- R6: Codes 13, 14 and 15 give low indices 0, 1 and 2 with high index 3. Code 0 gives low index 3 with high index 3.
- R7: While the synchronised enable is low, `lowRun` and `highRun` are both 0, whatever is on `keyCode`.
- R8: `mute` is 1 while idle. It goes to 0 on the same edge on which the channel enables turn on.
- R9: A tone keeps running for as long as `toneEnAsync` stays high. After `toneEnAsync` falls, both enables go to 0 and `mute` goes to 1 on the (SYNC_STAGES+1)-th rising edge.
- R10: If `singleToneN` is 0 at capture, only one channel runs. `groupSel`=1 runs only the high group and `groupSel`=0 runs only the low group. If `singleToneN` is 1, both channels run.
- R11: `singleToneN` and `groupSel` are sampled only at capture. Changing them during a tone has no effect on the running enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| toneEnAsync | input | 1 | Tone-enable strobe from the processor, not yet synchronised |
| keyCode | input | 4 | Binary key code, shared bus |
| singleToneN | input | 1 | Active-low single-tone test mode |
| groupSel | input | 1 | In single-tone mode, 1 selects the high group and 0 the low group |
| lowRatio | output | RATIO_W | Divide ratio for the low-group channel |
| highRatio | output | RATIO_W | Divide ratio for the high-group channel |
| lowRun | output | 1 | Low-group channel enable |
| highRun | output | 1 | High-group channel enable |
| mute | output | 1 | Speech-path mute, 1 while no tone is active |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This moves the capture edge to the fourth clock, so a design that hard-wires a two-flop delay shows up on both the start and stop latency checks. The ratio parameters keep their defaults, so all sixteen codes can be compared against the frequency tables written in the requirements. Every code is sampled one edge before and on the capture edge, which shows that nothing leaks through early.

// File: rtl/dtmf_cmd_pkg.sv
package dtmf_cmd_pkg;

  localparam int KEY_W   = 4;
  localparam int TONES   = 4;
  localparam int IDX_W   = $clog2(TONES);
  localparam int GROUPS  = 2;

  typedef struct packed {
    logic start;
    logic stop;
  } ctrl_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_TONE = 1'b1
  } tone_state_t;

  typedef struct packed {
    logic [IDX_W-1:0] row;
    logic [IDX_W-1:0] col;
  } pair_idx_t;

  // Maps a binary key code onto a (low index, high index) pair.
  function automatic pair_idx_t decode_key(input logic [KEY_W-1:0] code);
    pair_idx_t p;
    case (code)
      4'd1:  p = '{row: 2'd0, col: 2'd0};
      4'd2:  p = '{row: 2'd0, col: 2'd1};
      4'd3:  p = '{row: 2'd0, col: 2'd2};
      4'd4:  p = '{row: 2'd1, col: 2'd0};
      4'd5:  p = '{row: 2'd1, col: 2'd1};
      4'd6:  p = '{row: 2'd1, col: 2'd2};
      4'd7:  p = '{row: 2'd2, col: 2'd0};
      4'd8:  p = '{row: 2'd2, col: 2'd1};
      4'd9:  p = '{row: 2'd2, col: 2'd2};
      4'd10: p = '{row: 2'd3, col: 2'd1};
      4'd11: p = '{row: 2'd3, col: 2'd0};
      4'd12: p = '{row: 2'd3, col: 2'd2};
      4'd13: p = '{row: 2'd0, col: 2'd3};
      4'd14: p = '{row: 2'd1, col: 2'd3};
      4'd15: p = '{row: 2'd2, col: 2'd3};
      default: p = '{row: 2'd3, col: 2'd3};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dtmf_sync.sv
module dtmf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dtmf_tone_ctrl.sv
module dtmf_tone_ctrl
  import dtmf_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         toneEnAsync,
  output ctrl_strobe_t strobe,
  output logic         mute
);
  logic        enSync;
  logic        enPrev;
  tone_state_t state;
  tone_state_t stateNext;

  dtmf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (toneEnAsync),
    .dout (enSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enSync;
  end

  always_comb begin
    strobe.start = enSync && !enPrev && (state == ST_IDLE);
    strobe.stop  = !enSync && (state == ST_TONE);
    stateNext    = state;
    if (strobe.start)     stateNext = ST_TONE;
    else if (strobe.stop) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign mute = (state == ST_IDLE);

  // R8
  unmute_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> !mute);

  // R9
  mute_after_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enSync && !mute) |=> mute);

  // R2
  start_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> $rose(enSync));
endmodule

// File: rtl/dtmf_group_rom.sv
module dtmf_group_rom
  import dtmf_cmd_pkg::*;
#(
  parameter int                       RATIO_W = 8,
  parameter logic [TONES*RATIO_W-1:0] DIVS    = '0
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [RATIO_W-1:0] ratio
);
  assign ratio = DIVS[idx*RATIO_W +: RATIO_W];
endmodule

// File: rtl/dtmf_tone_datapath.sv
module dtmf_tone_datapath
  import dtmf_cmd_pkg::*;
#(
  parameter int                       RATIO_W   = 8,
  parameter logic [TONES*RATIO_W-1:0] LOW_DIVS  = '0,
  parameter logic [TONES*RATIO_W-1:0] HIGH_DIVS = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobe,
  input  logic [KEY_W-1:0]   keyCode,
  input  logic               singleToneN,
  input  logic               groupSel,
  output logic [RATIO_W-1:0] lowRatio,
  output logic [RATIO_W-1:0] highRatio,
  output logic               lowRun,
  output logic               highRun
);
  pair_idx_t          pair;
  logic [IDX_W-1:0]   idxArr   [GROUPS];
  logic [RATIO_W-1:0] ratioArr [GROUPS];

  assign pair      = decode_key(keyCode);
  assign idxArr[0] = pair.row;
  assign idxArr[1] = pair.col;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [TONES*RATIO_W-1:0] GDIVS = (g == 0) ? LOW_DIVS : HIGH_DIVS;
    dtmf_group_rom #(.RATIO_W(RATIO_W), .DIVS(GDIVS)) u_rom (
      .idx   (idxArr[g]),
      .ratio (ratioArr[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRatio  <= '0;
      highRatio <= '0;
    end else if (strobe.start) begin
      lowRatio  <= ratioArr[0];
      highRatio <= ratioArr[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= 1'b0;
      highRun <= 1'b0;
    end else if (strobe.start) begin
      lowRun  <= singleToneN || !groupSel;
      highRun <= singleToneN || groupSel;
    end else if (strobe.stop) begin
      lowRun  <= 1'b0;
      highRun <= 1'b0;
    end
  end

  // R3
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.start |=> ($stable(lowRatio) && $stable(highRatio)));

  // R10
  single_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && !singleToneN) |=> ($countones({lowRun, highRun}) == 1));

  // R11
  run_mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.start && !strobe.stop) |=> ($stable(lowRun) && $stable(highRun)));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.start && strobe.stop));
endmodule

// File: rtl/dtmf_cmd_ctrl.sv
module dtmf_cmd_ctrl
  import dtmf_cmd_pkg::*;
#(
  parameter int                       SYNC_STAGES = 2,
  parameter int                       RATIO_W     = 8,
  parameter logic [TONES*RATIO_W-1:0] LOW_DIVS    = {8'd136, 8'd150, 8'd166, 8'd184},
  parameter logic [TONES*RATIO_W-1:0] HIGH_DIVS   = {8'd78, 8'd86, 8'd96, 8'd106}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               toneEnAsync,
  input  logic [3:0]         keyCode,
  input  logic               singleToneN,
  input  logic               groupSel,
  output logic [RATIO_W-1:0] lowRatio,
  output logic [RATIO_W-1:0] highRatio,
  output logic               lowRun,
  output logic               highRun,
  output logic               mute
);
  ctrl_strobe_t strobe;

  dtmf_tone_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .toneEnAsync (toneEnAsync),
    .strobe      (strobe),
    .mute        (mute)
  );

  dtmf_tone_datapath #(
    .RATIO_W   (RATIO_W),
    .LOW_DIVS  (LOW_DIVS),
    .HIGH_DIVS (HIGH_DIVS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .keyCode     (keyCode),
    .singleToneN (singleToneN),
    .groupSel    (groupSel),
    .lowRatio    (lowRatio),
    .highRatio   (highRatio),
    .lowRun      (lowRun),
    .highRun     (highRun)
  );

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    mute |-> (!lowRun && !highRun));
endmodule

// File: tb/dtmf_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module dtmf_cmd_ctrl_bench;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       toneEnAsync = 1'b0;
  logic [3:0] keyCode = 4'd0;
  logic       singleToneN = 1'b1;
  logic       groupSel = 1'b1;
  logic [7:0] lowRatio, highRatio;
  logic       lowRun, highRun, mute;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dtmf_cmd_ctrl #(.SYNC_STAGES(SYNC)) u_dtmf_cmd_ctrl (
    .clk(clk), .rstN(rstN), .toneEnAsync(toneEnAsync), .keyCode(keyCode),
    .singleToneN(singleToneN), .groupSel(groupSel), .lowRatio(lowRatio),
    .highRatio(highRatio), .lowRun(lowRun), .highRun(highRun), .mute(mute)
  );

  function automatic int expLow(input int code);
    case (code)
      1, 2, 3, 13: return 184;
      4, 5, 6, 14: return 166;
      7, 8, 9, 15: return 150;
      default:     return 136;
    endcase
  endfunction

  function automatic int expHigh(input int code);
    case (code)
      1, 4, 7, 11: return 106;
      2, 5, 8, 10: return 96;
      3, 6, 9, 12: return 86;
      default:     return 78;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic raiseEnable(input int code, input bit stN, input bit gs);
    @(negedge clk);
    keyCode = code[3:0]; singleToneN = stN; groupSel = gs; toneEnAsync = 1'b1;
  endtask

  task automatic dropEnable();
    @(negedge clk);
    toneEnAsync = 1'b0;
    waitEdges(LAT + 2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 mute", mute, 1);
    check("R1 runs", {lowRun, highRun}, 0);
    check("R1 lowRatio", lowRatio, 0);
    check("R1 highRatio", highRatio, 0);
  endtask

  task automatic t_all_codes();
    for (int c = 0; c < 16; c++) begin
      raiseEnable(c, 1'b1, 1'b1);
      waitEdges(LAT - 1);
      check("R2 not yet mute", mute, 1);
      check("R7 not yet runs", {lowRun, highRun}, 0);
      waitEdges(1);
      check("R8 mute released", mute, 0);
      check("R10 both run", {lowRun, highRun}, 3);
      if (c >= 1 && c <= 9) begin
        check("R4 low", lowRatio, expLow(c));
        check("R4 high", highRatio, expHigh(c));
      end else if (c >= 10 && c <= 12) begin
        check("R5 low", lowRatio, expLow(c));
        check("R5 high", highRatio, expHigh(c));
      end else begin
        check("R6 low", lowRatio, expLow(c));
        check("R6 high", highRatio, expHigh(c));
      end
      dropEnable();
    end
  endtask

  task automatic t_stop_timing();
    raiseEnable(5, 1'b1, 1'b1);
    waitEdges(LAT + 20);
    check("R9 still running", {lowRun, highRun}, 3);
    toneEnAsync = 1'b0;
    waitEdges(LAT - 1);
    check("R9 not yet stopped", {lowRun, highRun}, 3);
    check("R9 not yet muted", mute, 0);
    waitEdges(1);
    check("R9 stopped", {lowRun, highRun}, 0);
    check("R8 muted", mute, 1);
    waitEdges(2);
  endtask

  task automatic t_ignore_data();
    raiseEnable(8, 1'b1, 1'b1);
    waitEdges(LAT);
    keyCode = 4'd13;
    waitEdges(6);
    check("R3 low held on", lowRatio, 150);
    check("R3 high held on", highRatio, 96);
    dropEnable();
    keyCode = 4'd1;
    waitEdges(6);
    check("R3 low held idle", lowRatio, 150);
    check("R3 high held idle", highRatio, 96);
    check("R7 idle runs", {lowRun, highRun}, 0);
    check("R7 idle mute", mute, 1);
  endtask

  task automatic t_single_tone();
    raiseEnable(11, 1'b0, 1'b1);
    waitEdges(LAT);
    check("R10 high only", {lowRun, highRun}, 1);
    check("R10 high ratio", highRatio, 106);
    dropEnable();
    raiseEnable(11, 1'b0, 1'b0);
    waitEdges(LAT);
    check("R10 low only", {lowRun, highRun}, 2);
    check("R10 low ratio", lowRatio, 136);
    singleToneN = 1'b1; groupSel = 1'b1;
    waitEdges(5);
    check("R11 mode held", {lowRun, highRun}, 2);
    check("R11 mute", mute, 0);
    dropEnable();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_all_codes();
    t_stop_timing();
    t_ignore_data();
    t_single_tone();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule